// File: doc/BRIEF.md
# Four-Beat Burst Address Generator

This block produces the address sequence for a four-beat memory burst. When either of two access-start strobes is raised, the block captures a full starting address and the value of a sequence-select input. After that it holds the captured upper address bits fixed. It moves the two least significant bits through one of two orders each time an advance input is raised at a clock edge.

In interleaved order, the low bits of beat k are the start bits XOR k. In linear order, they are the start bits plus k, modulo four. The block drives the current full address and the index of the current beat. The memory array, bus steering and chip-select logic belong to the surrounding design.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first load, `addr_o` is all zeros and `beat_o` is 0.
- R2: A rising clock edge with `start_cpu_i` or `start_ctl_i` high (either one, or both) loads `addr_i`. After that edge `addr_o` equals `addr_i` and `beat_o` is 0.
- R3: `step_i` has no effect at an edge where a load occurs. The beat index after that edge is 0, not 1.
- R4: With `seq_lin_i` = 0 sampled at load (interleaved), `addr_o[1:0]` equals start[1:0] XOR `beat_o`.
- R5: With `seq_lin_i` = 1 sampled at load (linear), `addr_o[1:0]` equals (start[1:0] + `beat_o`) mod 4. For example, a burst from start 2 runs 2, 3, 0, 1.
- R6: At an edge with no load and `step_i` high, `beat_o` increases by one, modulo 4. With `step_i` low, `addr_o` and `beat_o` hold.
- R7: Between loads, `addr_o[ADDR_W-1:2]` never changes, even when the beat wraps past the fourth beat.
- R8: `seq_lin_i` is used only at a load edge. Changing it during a burst does not alter the sequence.
- R9: After beat 3, a further step returns to beat 0 and to the starting address, so the burst keeps cycling within the same four-address block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| start_cpu_i | input | 1 | Access start from the processor side; loads the address |
| start_ctl_i | input | 1 | Access start from the controller side; loads the address |
| step_i | input | 1 | Advance the burst by one beat |
| seq_lin_i | input | 1 | Sequence select: 0 interleaved, 1 linear; sampled at load |
| addr_i | input | ADDR_W | Starting address of the burst |
| addr_o | output | ADDR_W | Current burst address |
| beat_o | output | 2 | Index of the current beat, 0 to 3 |

## Verification
Every result is due one edge after the stimulus that causes it. A load or a step presented at one rising edge shows on `addr_o` and `beat_o` right after that edge, because the outputs come straight from registers through XOR or add logic. The bench drives inputs at the falling edge. It then samples at the next falling edge, after exactly one rising edge, and compares with the address computed in the bench for that beat. The bench sweeps both sequences, all four starts and both strobes, and steps eight beats per burst to cover the wrap. It also checks hold, a load that collides with a step, and a sequence-select change in mid-burst, each at the same one-edge latency.

// File: rtl/burst_addr_pkg.sv
package burst_addr_pkg;

    localparam int BEAT_W = 2;

    typedef enum logic {
        SEQ_XOR = 1'b0,
        SEQ_LIN = 1'b1
    } seq_mode_e;

    function automatic logic [BEAT_W-1:0] low_bits(input seq_mode_e mode,
                                                   input logic [BEAT_W-1:0] start,
                                                   input logic [BEAT_W-1:0] beat);
        if (mode == SEQ_LIN) return start + beat;
        return start ^ beat;
    endfunction

endpackage

// File: rtl/burst_ctrl.sv
module burst_ctrl
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic                     step_i,
    input  seq_mode_e                mode_i,
    input  logic [ADDR_W-1:0]        addr_i,
    output logic [ADDR_W-BEAT_W-1:0] upper_o,
    output logic [BEAT_W-1:0]        start_o,
    output logic [BEAT_W-1:0]        beat_o,
    output seq_mode_e                mode_o
);
    localparam int HI_W = ADDR_W - BEAT_W;

    typedef struct packed {
        logic [HI_W-1:0]   upper;
        logic [BEAT_W-1:0] start;
        logic [BEAT_W-1:0] beat;
        seq_mode_e         mode;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.upper = addr_i[ADDR_W-1:BEAT_W];
            st_d.start = addr_i[BEAT_W-1:0];
            st_d.beat  = '0;
            st_d.mode  = mode_i;
        end else if (step_i) begin
            st_d.beat  = st_q.beat + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{upper: '0, start: '0, beat: '0, mode: SEQ_XOR};
        else        st_q <= st_d;
    end

    assign upper_o = st_q.upper;
    assign start_o = st_q.start;
    assign beat_o  = st_q.beat;
    assign mode_o  = st_q.mode;
endmodule

// File: rtl/burst_order.sv
module burst_order
    import burst_addr_pkg::*;
(
    input  seq_mode_e         mode_i,
    input  logic [BEAT_W-1:0] start_i,
    input  logic [BEAT_W-1:0] beat_i,
    output logic [BEAT_W-1:0] low_o
);
    always_comb low_o = low_bits(mode_i, start_i, beat_i);
endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_addr_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_cpu_i,
    input  logic              start_ctl_i,
    input  logic              step_i,
    input  logic              seq_lin_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [1:0]        beat_o
);
    localparam int HI_W = ADDR_W - BEAT_W;

    logic              load;
    logic [HI_W-1:0]   upper;
    logic [BEAT_W-1:0] start;
    logic [BEAT_W-1:0] beat;
    logic [BEAT_W-1:0] low;
    seq_mode_e         mode_cur;
    seq_mode_e         mode_in;

    assign load    = start_cpu_i | start_ctl_i;
    assign mode_in = seq_lin_i ? SEQ_LIN : SEQ_XOR;

    burst_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .step_i  (step_i),
        .mode_i  (mode_in),
        .addr_i  (addr_i),
        .upper_o (upper),
        .start_o (start),
        .beat_o  (beat),
        .mode_o  (mode_cur)
    );

    burst_order u_order (
        .mode_i  (mode_cur),
        .start_i (start),
        .beat_i  (beat),
        .low_o   (low)
    );

    assign addr_o = {upper, low};
    assign beat_o = beat;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_cpu_i,
    input logic              start_ctl_i,
    input logic              step_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic [1:0]        beat_o,
    input logic              mode_cur
);
    logic ld;
    assign ld = start_cpu_i | start_ctl_i;

    always_comb begin
        if (!rst_n) begin
            assert_reset_beat_R1: assert (beat_o == 2'd0 || $isunknown(beat_o));
        end
    end

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> (addr_o == $past(addr_i)) && (beat_o == 2'd0));

    assert_load_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld && step_i) |=> beat_o == 2'd0);

    assert_xor_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !mode_cur) |=> ((addr_o[1:0] ^ beat_o) == $past(addr_o[1:0] ^ beat_o)));

    assert_lin_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && mode_cur) |=> ((addr_o[1:0] - beat_o) == $past(addr_o[1:0] - beat_o)));

    assert_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && step_i) |=> beat_o == $past(beat_o) + 2'd1);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !step_i) |=> $stable(addr_o) && $stable(beat_o));

    assert_upper_fixed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> addr_o[ADDR_W-1:2] == $past(addr_o[ADDR_W-1:2]));

    assert_mode_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ld |=> $stable(mode_cur));
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_cpu_i (start_cpu_i),
    .start_ctl_i (start_ctl_i),
    .step_i      (step_i),
    .addr_i      (addr_i),
    .addr_o      (addr_o),
    .beat_o      (beat_o),
    .mode_cur    (mode_cur)
);

// File: tb/burst_addr_gen_tb.sv
module burst_addr_gen_tb;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_cpu_i = 1'b0;
    logic          start_ctl_i = 1'b0;
    logic          step_i = 1'b0;
    logic          seq_lin_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [AW-1:0] addr_o;
    logic [1:0]    beat_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(AW)) u_dut (.*);

    task automatic check(input string req, input logic [AW+1:0] act, input logic [AW+1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: addr/beat actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_lo(input bit lin, input int s, input int k);
        return lin ? 2'((s + k) % 4) : 2'(s ^ (k % 4));
    endfunction

    // one rising edge, then sample at the falling edge
    task automatic tick();
        @(negedge clk);
        start_cpu_i = 0; start_ctl_i = 0; step_i = 0;
    endtask

    initial begin
        logic [AW-3:0] up;
        repeat (3) @(negedge clk);
        check("R1 in reset", {addr_o, beat_o}, '0);
        rst_n = 1;
        tick();
        check("R1 after release", {addr_o, beat_o}, '0);

        // R2/R4/R5/R6/R7/R9 sweep
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 4; s++)
                for (int w = 0; w < 2; w++) begin
                    up = (AW-2)'(16'h1A5 * (m * 8 + s * 2 + w + 1));
                    addr_i = {up, 2'(s)};
                    seq_lin_i = m[0];
                    if (w == 0) start_cpu_i = 1; else start_ctl_i = 1;
                    tick();
                    addr_i = ~addr_i;
                    seq_lin_i = ~seq_lin_i; // R8: ignored mid-burst
                    check("R2 load", {addr_o, beat_o}, {up, 2'(s), 2'd0});
                    for (int k = 1; k < 9; k++) begin
                        step_i = 1;
                        tick();
                        check(m ? "R5/R7/R8/R9 linear beat" : "R4/R7/R8/R9 xor beat",
                              {addr_o, beat_o}, {up, exp_lo(m[0], s, k), 2'(k % 4)});
                    end
                end

        // R6 hold without step
        addr_i = 16'hBEE2; seq_lin_i = 1; start_ctl_i = 1;
        tick();
        step_i = 1; tick();
        for (int k = 0; k < 3; k++) begin
            tick();
            check("R6 hold", {addr_o, beat_o}, {14'(16'hBEE2 >> 2), 2'd3, 2'd1});
        end

        // R3 step during load
        step_i = 1; tick();
        addr_i = 16'h4441; seq_lin_i = 0; start_cpu_i = 1; step_i = 1;
        tick();
        check("R3 load beats step", {addr_o, beat_o}, {16'h4441, 2'd0});
        // both strobes at once, R2
        addr_i = 16'h7773; start_cpu_i = 1; start_ctl_i = 1; seq_lin_i = 1;
        tick();
        check("R2 both strobes", {addr_o, beat_o}, {16'h7773, 2'd0});
        step_i = 1; tick();
        check("R5 linear 3->0", {addr_o, beat_o}, {16'h7770, 2'd1});
        // reload in mid-burst, R2
        addr_i = 16'h0012; seq_lin_i = 0; start_cpu_i = 1;
        tick();
        check("R2 reload mid-burst", {addr_o, beat_o}, {16'h0012, 2'd0});
        step_i = 1; tick();
        check("R4 xor from 10", {addr_o, beat_o}, {16'h0013, 2'd1});

        done = 1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule